// File: doc/BRIEF.md
# Protection-Distance Bypass Decider for an L1 Data Cache

This block keeps a small protection counter for each line of a set-associative L1 data cache. For every miss, it decides whether the request should skip the cache and go straight to the next level. A line that was just filled, or that was just hit, is protected for a fixed number of later accesses to its set. Each access to the set lowers the protection of the other lines in that set. A line whose counter has reached zero is no longer protected and may be replaced.

When a miss arrives, the block looks at the counters of the addressed set together with the per-way reservation flags supplied by the miss-handling logic. A way is a usable victim only if its counter is zero and it is not reserved for a pending fill. If no way in the set is usable, the request is marked as a bypass. Otherwise the lowest-numbered usable way is reported as the victim. The decision is combinational from the request inputs and the counter state. Counter updates take effect at the next clock edge. The block is active at all times and has no mode input.

Top module: `pdb_bypass_ctrl`

## Requirements
- R1: After reset every protection counter is zero, so a miss on any set with no reserved way selects way 0 and does not bypass.
- R2: A fill strobe loads the counter of the filled line with the protection value (4 by default). This protects the line for exactly that many later accesses to its set.
- R3: Each valid request lowers counters in its set by one, saturating at zero and never wrapping. A hit ages every way except the hit way. A miss ages every way of the set.
- R4: A hit reloads the counter of the hit way with the protection value.
- R5: A valid miss raises `bypass_o` when every way of its set has a non-zero counter or has its reservation flag set.
- R6: A valid miss that does not bypass raises `victim_valid_o`. It reports on `victim_way_o` the lowest-numbered way whose counter is zero and whose reservation flag is clear.
- R7: A hit request, or a cycle without a valid request, raises neither `bypass_o` nor `victim_valid_o`.
- R8: When a fill targets the same line that a request in the same cycle would age, the fill wins and the counter holds the protection value.
- R9: Requests and fills change only the counters of the set they address.
- R10: No counter ever holds a value above the protection value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | A cache request is presented this cycle |
| req_set_i | input | SET_W (5) | Set addressed by the request |
| req_hit_i | input | 1 | The request hit in the tag array |
| req_hit_way_i | input | WAY_W (2) | Way that hit, valid when `req_hit_i` is 1 |
| fill_valid_i | input | 1 | A line is being written by a returning fill |
| fill_set_i | input | SET_W (5) | Set of the filled line |
| fill_way_i | input | WAY_W (2) | Way of the filled line |
| rsv_mask_i | input | WAYS (4) | Per-way reservation flags for the requested set, bit n is way n |
| bypass_o | output | 1 | The miss must skip the cache |
| victim_valid_o | output | 1 | A victim way is offered for the miss |
| victim_way_o | output | WAY_W (2) | Chosen victim way |

## Verification
The bench builds the block with its default values: 4 ways, 32 sets, 3-bit counters and a protection value of 4. With these values the complete protection window of a line, four accesses from fill to expiry, is short enough to walk through access by access, so the last protected access and the first unprotected access can both be observed. The bench also runs random traffic confined to four sets. This produces frequent fill and request collisions on the same line, and it exercises every pattern of reservation flags against every mix of counter values.

// File: rtl/pdb_pkg.sv
package pdb_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE = 2'd0,
    ACC_HIT  = 2'd1,
    ACC_MISS = 2'd2
  } acc_kind_e;

  function automatic acc_kind_e classify_access(input logic touches_set, input logic is_hit);
    if (!touches_set) return ACC_IDLE;
    return is_hit ? ACC_HIT : ACC_MISS;
  endfunction

endpackage

// File: rtl/pdb_rpd_bank.sv
module pdb_rpd_bank #(
  parameter int unsigned WAYS     = 4,
  parameter int unsigned SETS     = 32,
  parameter int unsigned RPD_W    = 3,
  parameter int unsigned RPD_INIT = 4,
  localparam int unsigned WAY_W   = $clog2(WAYS),
  localparam int unsigned SET_W   = $clog2(SETS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  input  logic [SET_W-1:0]      req_set_i,
  input  logic                  req_hit_i,
  input  logic [WAY_W-1:0]      req_hit_way_i,
  input  logic                  fill_valid_i,
  input  logic [SET_W-1:0]      fill_set_i,
  input  logic [WAY_W-1:0]      fill_way_i,
  output logic [WAYS*RPD_W-1:0] rd_rpd_o
);
  import pdb_pkg::*;

  localparam int unsigned LINES = SETS * WAYS;
  localparam logic [RPD_W-1:0] PROT = RPD_W'(RPD_INIT);

  logic [RPD_W-1:0] cnt_arr [LINES];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    acc_kind_e kind;
    assign kind = classify_access(req_valid_i && (req_set_i == SET_W'(s)), req_hit_i);

    for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic [RPD_W-1:0] cnt_q, cnt_d;
      logic             cnt_en;
      logic             fill_here;

      assign fill_here = fill_valid_i && (fill_set_i == SET_W'(s)) && (fill_way_i == WAY_W'(w));

      // next-state: age, refresh on hit, fill has the last word
      always_comb begin
        cnt_d  = cnt_q;
        cnt_en = 1'b0;
        unique case (kind)
          ACC_HIT: begin
            cnt_en = 1'b1;
            if (req_hit_way_i == WAY_W'(w)) cnt_d = PROT;
            else if (cnt_q != '0)           cnt_d = cnt_q - 1'b1;
          end
          ACC_MISS: begin
            cnt_en = 1'b1;
            if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
          end
          default: ;
        endcase
        if (fill_here) begin
          cnt_en = 1'b1;
          cnt_d  = PROT;
        end
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     cnt_q <= '0;
        else if (cnt_en) cnt_q <= cnt_d;
      end

      assign cnt_arr[s*WAYS + w] = cnt_q;
    end
  end

  // read port for the requested set
  always_comb begin
    rd_rpd_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      rd_rpd_o[w*RPD_W +: RPD_W] = cnt_arr[int'(req_set_i)*WAYS + w];
    end
  end

endmodule

// File: rtl/pdb_way_select.sv
module pdb_way_select #(
  parameter int unsigned WAYS   = 4,
  parameter int unsigned RPD_W  = 3,
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic                  req_valid_i,
  input  logic                  req_hit_i,
  input  logic [WAYS*RPD_W-1:0] rd_rpd_i,
  input  logic [WAYS-1:0]       rsv_mask_i,
  output logic                  bypass_o,
  output logic                  victim_valid_o,
  output logic [WAY_W-1:0]      victim_way_o
);
  logic [WAYS-1:0] usable;
  logic            is_miss;

  for (genvar w = 0; w < WAYS; w++) begin : g_cand
    assign usable[w] = (rd_rpd_i[w*RPD_W +: RPD_W] == '0) && !rsv_mask_i[w];
  end

  assign is_miss = req_valid_i && !req_hit_i;

  // lowest usable way wins: scan from the top down
  always_comb begin
    victim_way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (usable[w]) victim_way_o = WAY_W'(w);
    end
  end

  assign bypass_o       = is_miss && (usable == '0);
  assign victim_valid_o = is_miss && (usable != '0);

endmodule

// File: rtl/pdb_bypass_ctrl.sv
module pdb_bypass_ctrl #(
  parameter int unsigned WAYS     = 4,
  parameter int unsigned SETS     = 32,
  parameter int unsigned RPD_W    = 3,
  parameter int unsigned RPD_INIT = 4,
  localparam int unsigned WAY_W   = $clog2(WAYS),
  localparam int unsigned SET_W   = $clog2(SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [SET_W-1:0] req_set_i,
  input  logic             req_hit_i,
  input  logic [WAY_W-1:0] req_hit_way_i,
  input  logic             fill_valid_i,
  input  logic [SET_W-1:0] fill_set_i,
  input  logic [WAY_W-1:0] fill_way_i,
  input  logic [WAYS-1:0]  rsv_mask_i,
  output logic             bypass_o,
  output logic             victim_valid_o,
  output logic [WAY_W-1:0] victim_way_o
);
  logic [WAYS*RPD_W-1:0] rd_rpd;

  pdb_rpd_bank #(
    .WAYS(WAYS), .SETS(SETS), .RPD_W(RPD_W), .RPD_INIT(RPD_INIT)
  ) u_bank (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_valid_i   (req_valid_i),
    .req_set_i     (req_set_i),
    .req_hit_i     (req_hit_i),
    .req_hit_way_i (req_hit_way_i),
    .fill_valid_i  (fill_valid_i),
    .fill_set_i    (fill_set_i),
    .fill_way_i    (fill_way_i),
    .rd_rpd_o      (rd_rpd)
  );

  pdb_way_select #(
    .WAYS(WAYS), .RPD_W(RPD_W)
  ) u_sel (
    .req_valid_i    (req_valid_i),
    .req_hit_i      (req_hit_i),
    .rd_rpd_i       (rd_rpd),
    .rsv_mask_i     (rsv_mask_i),
    .bypass_o       (bypass_o),
    .victim_valid_o (victim_valid_o),
    .victim_way_o   (victim_way_o)
  );

endmodule

// File: rtl/pdb_bypass_chk.sv
module pdb_bypass_chk #(
  parameter int unsigned WAYS     = 4,
  parameter int unsigned SETS     = 32,
  parameter int unsigned RPD_W    = 3,
  parameter int unsigned RPD_INIT = 4,
  localparam int unsigned WAY_W   = $clog2(WAYS),
  localparam int unsigned SET_W   = $clog2(SETS)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  req_valid_i,
  input logic [SET_W-1:0]      req_set_i,
  input logic                  req_hit_i,
  input logic [WAY_W-1:0]      req_hit_way_i,
  input logic                  fill_valid_i,
  input logic [WAYS-1:0]       rsv_mask_i,
  input logic [WAYS*RPD_W-1:0] rd_rpd,
  input logic                  bypass_o,
  input logic                  victim_valid_o,
  input logic [WAY_W-1:0]      victim_way_o
);
  localparam logic [RPD_W-1:0] PROT = RPD_W'(RPD_INIT);

  assert_exclusive_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bypass_o && victim_valid_o));

  assert_hit_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_valid_i || req_hit_i) |-> (!bypass_o && !victim_valid_o));

  assert_victim_free_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    victim_valid_o |-> (!rsv_mask_i[victim_way_o] &&
                        rd_rpd[int'(victim_way_o)*RPD_W +: RPD_W] == '0));

  for (genvar w = 0; w < WAYS; w++) begin : g_w
    assert_no_overflow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_rpd[w*RPD_W +: RPD_W] <= PROT);

    assert_bypass_blocked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bypass_o |-> (rsv_mask_i[w] || rd_rpd[w*RPD_W +: RPD_W] != '0));

    assert_miss_ages_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && !req_hit_i && !fill_valid_i) |=>
        (req_set_i != $past(req_set_i)) ||
        (rd_rpd[w*RPD_W +: RPD_W] ==
          (($past(rd_rpd[w*RPD_W +: RPD_W]) == '0) ? '0
                                                   : $past(rd_rpd[w*RPD_W +: RPD_W]) - 1'b1)));

    assert_hit_reload_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && req_hit_i && req_hit_way_i == WAY_W'(w)) |=>
        (req_set_i != $past(req_set_i)) || (rd_rpd[w*RPD_W +: RPD_W] == PROT));
  end

endmodule

bind pdb_bypass_ctrl pdb_bypass_chk #(
  .WAYS(WAYS), .SETS(SETS), .RPD_W(RPD_W), .RPD_INIT(RPD_INIT)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_valid_i    (req_valid_i),
  .req_set_i      (req_set_i),
  .req_hit_i      (req_hit_i),
  .req_hit_way_i  (req_hit_way_i),
  .fill_valid_i   (fill_valid_i),
  .rsv_mask_i     (rsv_mask_i),
  .rd_rpd         (rd_rpd),
  .bypass_o       (bypass_o),
  .victim_valid_o (victim_valid_o),
  .victim_way_o   (victim_way_o)
);

// File: tb/sim_pdb_bypass_ctrl.sv
module sim_pdb_bypass_ctrl;
  localparam int WAYS = 4;
  localparam int SETS = 32;
  localparam int PROT = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid, req_hit, fill_valid;
  logic [4:0] req_set, fill_set;
  logic [1:0] req_hit_way, fill_way;
  logic [3:0] rsv_mask;
  logic       bypass, victim_valid;
  logic [1:0] victim_way;

  int checks = 0;
  int errors = 0;
  int model [SETS][WAYS];

  always #10 clk = ~clk;

  pdb_bypass_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_set_i(req_set), .req_hit_i(req_hit),
    .req_hit_way_i(req_hit_way), .fill_valid_i(fill_valid), .fill_set_i(fill_set),
    .fill_way_i(fill_way), .rsv_mask_i(rsv_mask),
    .bypass_o(bypass), .victim_valid_o(victim_valid), .victim_way_o(victim_way)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // one cycle: drive at negedge, compare before posedge, advance model after it
  task automatic step(input logic v, input logic h, input int hw, input int s,
                      input logic fv, input int fs, input int fw,
                      input logic [3:0] rsv, input string tag);
    logic exp_byp, exp_vv;
    int   exp_vw;
    @(negedge clk);
    req_valid = v; req_hit = h; req_hit_way = 2'(hw); req_set = 5'(s);
    fill_valid = fv; fill_set = 5'(fs); fill_way = 2'(fw); rsv_mask = rsv;
    #5;
    exp_byp = 1'b0; exp_vv = 1'b0; exp_vw = 0;
    if (v && !h) begin
      exp_vw = -1;
      for (int w = WAYS - 1; w >= 0; w--)
        if (model[s][w] == 0 && !rsv[w]) exp_vw = w;
      if (exp_vw < 0) begin exp_byp = 1'b1; exp_vw = 0; end
      else exp_vv = 1'b1;
    end
    checks++;
    if (bypass !== exp_byp || victim_valid !== exp_vv ||
        (exp_vv && int'(victim_way) != exp_vw)) begin
      errors++;
      $display("FAIL %s: got byp=%0b vv=%0b way=%0d, expected byp=%0b vv=%0b way=%0d",
               tag, bypass, victim_valid, victim_way, exp_byp, exp_vv, exp_vw);
    end
    @(posedge clk);
    #1;
    if (v)
      for (int w = 0; w < WAYS; w++) begin
        if (h && w == hw) model[s][w] = PROT;
        else if (model[s][w] > 0) model[s][w]--;
      end
    if (fv) model[fs][fw] = PROT;
  endtask

  task automatic idle_cycle();
    step(1'b0, 1'b0, 0, 0, 1'b0, 0, 0, 4'h0, "R7 idle");
  endtask

  task automatic fill_set_all(input int s);
    for (int w = 0; w < WAYS; w++) step(1'b0, 1'b0, 0, 0, 1'b1, s, w, 4'h0, "R2 fill");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int s = 0; s < SETS; s++) for (int w = 0; w < WAYS; w++) model[s][w] = 0;
    rst_n = 1'b0; req_valid = 0; req_hit = 0; req_hit_way = 0; req_set = 0;
    fill_valid = 0; fill_set = 0; fill_way = 0; rsv_mask = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state seen through a few sets
    step(1'b1, 1'b0, 0, 0,  1'b0, 0, 0, 4'h0, "R1 reset set0");
    step(1'b1, 1'b0, 0, 17, 1'b0, 0, 0, 4'h0, "R1 reset set17");
    step(1'b1, 1'b0, 0, 31, 1'b0, 0, 0, 4'h0, "R1 reset set31");
    idle_cycle();

    // R2/R3/R5: four protected misses, then the first unprotected one
    fill_set_all(3);
    for (int k = 0; k < PROT; k++) step(1'b1, 1'b0, 0, 3, 1'b0, 0, 0, 4'h0, "R5 bypass protected");
    step(1'b1, 1'b0, 0, 3, 1'b0, 0, 0, 4'h0, "R2 expiry");
    // R3 saturation: many misses on zero counters
    for (int k = 0; k < 6; k++) step(1'b1, 1'b0, 0, 3, 1'b0, 0, 0, 4'h0, "R3 saturate");

    // R6 reservation steering and full reservation
    step(1'b1, 1'b0, 0, 3, 1'b0, 0, 0, 4'b0111, "R6 lowest unreserved");
    step(1'b1, 1'b0, 0, 3, 1'b0, 0, 0, 4'b0101, "R6 skip reserved");
    step(1'b1, 1'b0, 0, 3, 1'b0, 0, 0, 4'b1111, "R5 all reserved");

    // R4/R7: hit refresh keeps way 2 protected while others expire
    fill_set_all(5);
    for (int k = 0; k < 6; k++) step(1'b1, 1'b1, 2, 5, 1'b0, 0, 0, 4'h0, "R7 hit quiet");
    step(1'b1, 1'b0, 0, 5, 1'b0, 0, 0, 4'b0011, "R4 hit way protected");
    step(1'b1, 1'b0, 0, 5, 1'b0, 0, 0, 4'b1011, "R4 only hit way left");

    // R8: fill and miss on the same line in one cycle
    step(1'b1, 1'b0, 0, 5, 1'b1, 5, 1, 4'h0, "R8 collide");
    step(1'b1, 1'b0, 0, 5, 1'b0, 0, 0, 4'b1101, "R8 fill wins");

    // R9: set 7 stays protected while set 8 is hammered
    fill_set_all(7);
    for (int k = 0; k < 6; k++) step(1'b1, 1'b0, 0, 8, 1'b0, 0, 0, 4'h0, "R9 other set");
    step(1'b1, 1'b0, 0, 7, 1'b0, 0, 0, 4'h0, "R9 untouched");

    // random traffic on four sets: mixes of R3 R4 R5 R6 R8 R10
    for (int k = 0; k < 4000; k++) begin
      logic v, h, fv;
      v  = ($urandom % 4) != 0;
      h  = ($urandom % 3) == 0;
      fv = ($urandom % 3) == 0;
      step(v, h, int'($urandom % 4), int'($urandom % 4), fv, int'($urandom % 4),
           int'($urandom % 4), 4'($urandom & $urandom), "R10 random");
    end

    summary();
    $finish;
  end
endmodule